// File: doc/BRIEF.md
# Smart Panel Command Bus Master

This block is the bus master for a smart display panel that takes commands and pixel data over a parallel, 8080-style strobed bus. It serves two panels, a main one and a sub one, which share the data bus, the register-select line and the write and read strobes. Each panel has its own chip select.

Software uses a small register port to drive the block. For a write, it first loads a write-data register. Two control bits in that register mark the word as valid and say whether it is a command (index) or a data word. Software then writes the write-access register to start the transfer. For a read, it loads the read-data register with the register-select level to use, then writes the read-access register. The returned bus value appears in the low half of the read-data register.

A status register shows a busy flag. Software must poll this flag before it starts the next access. The setup, strobe and hold widths of each bus cycle are set by parameters.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset, both chip selects, the write strobe and the read strobe are high. The data bus is not driven, the status register reads 0, and the write-data register reads 0.
- R2: A write to the write-access register (address 2) starts a write access when bit 0 of the written value is 1, bit 28 of the write-data register is 1 and the block is idle. Status bit 1 (busy) then reads 1 for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC cycles, counted from the cycle after the trigger. It reads 0 afterwards.
- R3: Bit 1 of the trigger value picks the channel: 0 for main and 1 for sub. The chosen chip select (cs_no[0] for main, cs_no[1] for sub) stays low for the whole busy time. The other chip select stays high.
- R4: During a write access, rs_o equals bit 24 of the write-data register: 0 for an index word, 1 for a data word. During a read access, rs_o equals bit 24 of the read-data register (address 1).
- R5: In a write access, wr_no is high for the first SETUP_CYC busy cycles, low for the next STROBE_CYC cycles, and high for the last HOLD_CYC cycles. Throughout the access, db_oe_o is 1 and db_o carries bits 15:0 of the write-data register.
- R6: A write to the read-access register (address 3) with bit 0 set, while the block is idle, starts a read access. The read access has the same phases as a write, but rd_no is the strobe and db_oe_o stays 0. The block samples db_i in the last strobe cycle and returns it in bits 15:0 of the read-data register once busy has fallen. Bit 24 of that register shows the read register-select level.
- R7: A trigger written while busy is ignored. The running access keeps its channel and its length.
- R8: A write trigger is ignored, and no chip select falls, when bit 0 of the trigger value is 0 or bit 28 of the write-data register is 0.
- R9: The status register (address 4) has busy in bit 1 and reads 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 write-data, 1 read-data, 2 write-access, 3 read-access, 4 status |
| reg_wdata_i | input | 32 | Register write value |
| reg_rdata_o | output | 32 | Register read value (combinational from address) |
| cs_no | output | 2 | Chip selects, active low; bit 0 main, bit 1 sub |
| rs_o | output | 1 | Register select: 0 index, 1 data |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| db_o | output | 16 | Data bus output value |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 16 | Data bus input value |

## Verification
A trigger written at one rising edge takes effect at that edge. The access is therefore in its first setup cycle at the next falling edge, and the bench numbers bus cycles from that point. At every falling edge the bench compares the strobes, chip selects, register-select, data bus and status busy bit with values it derives from the parameter widths and the cycle number. The cycle at index SETUP+STROBE+HOLD must be idle. Read data is checked only after that idle cycle, when it has been captured. Ignored triggers are checked by watching the chip selects and busy in the cycles that follow them.

// File: rtl/panel_cmd_bus_pkg.sv
package panel_cmd_bus_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  localparam logic [2:0] ADDR_WDATA = 3'd0;
  localparam logic [2:0] ADDR_RDATA = 3'd1;
  localparam logic [2:0] ADDR_WTRIG = 3'd2;
  localparam logic [2:0] ADDR_RTRIG = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;

  localparam int BIT_VALID = 28;
  localparam int BIT_RS    = 24;
  localparam int BIT_GO    = 0;
  localparam int BIT_CHAN  = 1;
  localparam int BIT_BUSY  = 1;
endpackage

// File: rtl/panel_bus_seq.sv
module panel_bus_seq
  import panel_cmd_bus_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MAXC  = (SETUP_CYC > STROBE_CYC) ?
                         ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                         ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC),
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            read_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            rs_i,
  input  logic [DW-1:0]   data_i,
  input  logic [DW-1:0]   db_i,
  output logic            busy_o,
  output logic [NCH-1:0]  cs_no,
  output logic            rs_o,
  output logic            wr_no,
  output logic            rd_no,
  output logic [DW-1:0]   db_o,
  output logic            db_oe_o,
  output logic            cap_valid_o,
  output logic [DW-1:0]   cap_data_o
);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;
  logic             rd_q, rs_q;
  logic [DW-1:0]    data_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      chan_q      <= '0;
      rd_q        <= 1'b0;
      rs_q        <= 1'b0;
      data_q      <= '0;
      cap_valid_o <= 1'b0;
      cap_data_o  <= '0;
    end else begin
      cap_valid_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= SETUP_LD;
          chan_q <= chan_i;
          rd_q   <= read_i;
          rs_q   <= rs_i;
          data_q <= data_i;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_STROBE;
          cnt_q <= STROBE_LD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= HOLD_LD;
          // sample the panel at the end of the read strobe
          if (rd_q) begin
            cap_valid_o <= 1'b1;
            cap_data_o  <= db_i;
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign rs_o    = rs_q;
  assign db_o    = data_q;
  assign db_oe_o = busy_o && !rd_q;
  assign wr_no   = !((ph_q == PH_STROBE) && !rd_q);
  assign rd_no   = !((ph_q == PH_STROBE) && rd_q);

  for (genvar i = 0; i < NCH; i++) begin : g_cs
    assign cs_no[i] = !(busy_o && (chan_q == CH_W'(i)));
  end

  p_one_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  p_cs_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cs_no));
  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !rd_no));
  p_wr_drives_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> db_oe_o && !(&cs_no));
  p_rd_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !db_oe_o);
  p_strobe_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) || $fell(rd_no) |-> $past(busy_o));
endmodule

// File: rtl/panel_bus_regs.sv
module panel_bus_regs
  import panel_cmd_bus_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            busy_i,
  input  logic            cap_valid_i,
  input  logic [DW-1:0]   cap_data_i,
  output logic            start_o,
  output logic            read_o,
  output logic [CH_W-1:0] chan_o,
  output logic            rs_o,
  output logic [DW-1:0]   data_o
);
  logic [31:0]   wdata_q;
  logic          rd_rs_q;
  logic [DW-1:0] rd_data_q;
  logic          wr_go, rd_go;

  assign wr_go = reg_we_i && (reg_addr_i == ADDR_WTRIG) && reg_wdata_i[BIT_GO]
                 && wdata_q[BIT_VALID] && !busy_i;
  assign rd_go = reg_we_i && (reg_addr_i == ADDR_RTRIG) && reg_wdata_i[BIT_GO]
                 && !busy_i;

  assign start_o = wr_go || rd_go;
  assign read_o  = rd_go;
  assign chan_o  = CH_W'(reg_wdata_i[BIT_CHAN]);
  assign rs_o    = rd_go ? rd_rs_q : wdata_q[BIT_RS];
  assign data_o  = wdata_q[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q   <= '0;
      rd_rs_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_WDATA) wdata_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == ADDR_RDATA) rd_rs_q <= reg_wdata_i[BIT_RS];
      if (cap_valid_i) rd_data_q <= cap_data_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_WDATA: reg_rdata_o = wdata_q;
      ADDR_RDATA: begin
        reg_rdata_o[DW-1:0]   = rd_data_q;
        reg_rdata_o[BIT_RS]   = rd_rs_q;
      end
      ADDR_STAT:  reg_rdata_o[BIT_BUSY] = busy_i;
      default:    reg_rdata_o = '0;
    endcase
  end

  p_no_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);
  p_need_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !read_o |-> wdata_q[BIT_VALID]);
endmodule

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus
  import panel_cmd_bus_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic [NCH-1:0] cs_no,
  output logic           rs_o,
  output logic           wr_no,
  output logic           rd_no,
  output logic [DW-1:0]  db_o,
  output logic           db_oe_o,
  input  logic [DW-1:0]  db_i
);
  logic            busy, start, read, rs, cap_valid;
  logic [CH_W-1:0] chan;
  logic [DW-1:0]   data, cap_data;

  panel_bus_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .cap_valid_i(cap_valid), .cap_data_i(cap_data),
    .start_o(start), .read_o(read), .chan_o(chan), .rs_o(rs), .data_o(data)
  );

  panel_bus_seq #(.NCH(NCH), .DW(DW), .SETUP_CYC(SETUP_CYC),
                  .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .read_i(read), .chan_i(chan),
    .rs_i(rs), .data_i(data), .db_i, .busy_o(busy), .cs_no, .rs_o,
    .wr_no, .rd_no, .db_o, .db_oe_o, .cap_valid_o(cap_valid),
    .cap_data_o(cap_data)
  );

  p_busy_after_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> reg_rdata_o[BIT_BUSY] || reg_addr_i != ADDR_STAT);
  p_cs_needs_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |-> busy);
endmodule

// File: tb/sim_panel_cmd_bus.sv
`timescale 1ns/1ps
module sim_panel_cmd_bus;
  localparam int S = 2, P = 3, H = 2, T = S + P + H;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  cs_n;
  logic        rs, wr_n, rd_n, oe;
  logic [15:0] dbo, dbi = '0;
  int vecs = 0, errs = 0;

  always #2 clk = ~clk;

  panel_cmd_bus #(.SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cs_no(cs_n), .rs_o(rs),
    .wr_no(wr_n), .rd_no(rd_n), .db_o(dbo), .db_oe_o(oe), .db_i(dbi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cs(input bit ch, input bit act);
    return act ? ~(2'b01 << ch) : 2'b11;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 3'd4;
  endtask

  task automatic check_idle(input string req);
    #1;
    chk(req, {30'b0, cs_n}, 32'h3);
    chk(req, rdata, 32'h0);
  endtask

  // one full access, checked cycle by cycle from the first setup cycle
  task automatic access(input bit rd, input bit ch, input bit rsv,
                        input logic [15:0] d, input bit inject);
    if (!rd) wr(3'd0, {3'b0, 1'b1, 3'b0, rsv, 8'h00, d});
    else begin
      wr(3'd1, {7'b0, rsv, 24'h0});
      dbi = d;
    end
    wr(rd ? 3'd3 : 3'd2, {30'b0, ch, 1'b1});
    for (int c = 0; c <= T; c++) begin
      bit act, stb;
      if (c > 0) begin
        @(negedge clk); we = 1'b0; addr = 3'd4;
      end
      #1;
      act = (c < T);
      stb = (c >= S) && (c < S + P);
      chk("R2 busy", {31'b0, rdata[1]}, {31'b0, act});
      chk("R9 status", {rdata[31:2], rdata[0]}, 31'b0);
      chk("R3 cs", {30'b0, cs_n}, {30'b0, exp_cs(ch, act)});
      if (act) chk("R4 rs", {31'b0, rs}, {31'b0, rsv});
      if (!rd) begin
        chk("R5 wr", {31'b0, wr_n}, {31'b0, !stb});
        chk("R5 oe", {31'b0, oe}, {31'b0, act});
        if (act) chk("R5 db", {16'b0, dbo}, {16'b0, d});
      end else begin
        chk("R6 rd", {31'b0, rd_n}, {31'b0, !stb});
        chk("R6 oe", {31'b0, oe}, 32'b0);
      end
      if (inject && c == 0) begin
        we = 1'b1; addr = rd ? 3'd3 : 3'd2; wdata = {30'b0, !ch, 1'b1};
      end
    end
    if (rd) begin
      @(negedge clk); addr = 3'd1; #1;
      chk("R6 rdata", rdata, {7'b0, rsv, 8'h00, d});
      addr = 3'd4;
    end
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd7717));
    #1;
    chk("R1 cs", {30'b0, cs_n}, 32'h3);
    chk("R1 strobes", {30'b0, wr_n, rd_n}, 32'h3);
    chk("R1 oe", {31'b0, oe}, 32'h0);
    chk("R1 status", rdata, 32'h0);
    addr = 3'd0; #1;
    chk("R1 wdata", rdata, 32'h0);
    addr = 3'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: no valid bit
    wr(3'd0, 32'h0100_1234);
    wr(3'd2, 32'h1);
    check_idle("R8 novalid");
    // R8: go bit clear
    wr(3'd0, 32'h1100_1234);
    wr(3'd2, 32'h2);
    check_idle("R8 nogo");
    // directed corners
    access(1'b0, 1'b0, 1'b0, 16'hA55A, 1'b0);
    access(1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b0);
    access(1'b1, 1'b1, 1'b1, 16'h0001, 1'b0);
    access(1'b0, 1'b0, 1'b1, 16'h8000, 1'b1); // R7 trigger while busy
    access(1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b1); // R7 on read
    check_idle("R7 after");
    for (int i = 0; i < 40; i++) begin
      access(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
             ($urandom % 4) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule